// File: doc/BRIEF.md
# Single-Wire Bus Slave Signaling Front End

This block is the slave-side physical layer of a single-wire open-drain bus. It receives the raw level of the bus line, passes it through a synchronizer, and drives a pull-low enable that an external open-drain pad turns into a low level on the wire. All timing is counted in clock cycles. The parameter `CYC_PER_US` gives the number of cycles in one microsecond, and every window is derived from it.

The master starts each time slot with a falling edge. At that edge the block latches the slot direction (`mode_read`) and the bit to send (`tx_bit`), both supplied by the user side. In a write slot the block samples the line 30 µs after the edge and returns the level with a one-cycle `bit_valid` strobe. In a read slot with a 0 to send, the block pulls the line low for 30 µs from the edge. With a 1 to send it leaves the line alone. A low period of at least 480 µs is a reset. It aborts any slot in progress. About 30 µs after the line rises again, the block drives a 120 µs presence pulse, and it strobes `reset_seen` when that pulse ends. A low period longer than the 120 µs slot timeout but shorter than a reset is dropped.

The controller has these states. `ST_IDLE` moves to `ST_SLOT_ACT` on a falling edge. `ST_SLOT_ACT` moves to `ST_SLOT_END` at the sample or hold point. `ST_SLOT_END` moves to `ST_IDLE` when the line is high, to `ST_LONG_LOW` when the low time passes the slot timeout, and to `ST_RST_LOW` when it reaches reset length. `ST_LONG_LOW` moves to `ST_IDLE` when the line is high and to `ST_RST_LOW` at reset length. `ST_RST_LOW` moves to `ST_PRES_WAIT` when the line is high. `ST_PRES_WAIT` moves to `ST_PRES_DRIVE` after the wait. `ST_PRES_DRIVE` moves to `ST_IDLE` after the pulse.

Top module: `sw_slave_phy`

## Requirements
- R1: While reset is active, and after it, until the bus acts, `pull_low`, `bit_valid` and `reset_seen` are 0.
- R2: In a write slot (`mode_read`=0 at the falling edge), `bit_valid` is high for exactly one cycle about 30 µs after the falling edge. `rx_bit` carries the line level at that point: 1 if the master has released the line, 0 if it still holds it low.
- R3: In a read slot with `tx_bit`=0, `pull_low` goes high within 3 cycles of the falling edge and stays high for 30 µs (120 cycles at 4 cycles/µs).
- R4: In a read slot with `tx_bit`=1, `pull_low` stays 0 for the whole slot.
- R5: A line low of at least 480 µs is a reset. After the line rises, `pull_low` stays 0 for about 30 µs and then stays high for 120 µs as the presence pulse.
- R6: `reset_seen` is a one-cycle strobe, given once per reset, in the cycle after the presence pulse ends.
- R7: A falling edge during the presence wait or the presence pulse starts no slot: it gives no `bit_valid`, and the presence timing does not change.
- R8: A low period that reaches reset length while a slot is in progress aborts the slot and is followed by a presence pulse.
- R9: A low period longer than 120 µs but shorter than 480 µs gives no presence pulse and no `reset_seen`. The block returns to idle, and the next write slot works.
- R10: `mode_read` and `tx_bit` are latched at the falling edge. A change to either during the slot does not change that slot's behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Raw, unsynchronized bus line level |
| mode_read | input | 1 | 1 = next slot is a read (slave sends), 0 = write (slave receives) |
| tx_bit | input | 1 | Bit the slave sends in a read slot |
| pull_low | output | 1 | 1 = enable the open-drain pull-down on the line |
| bit_valid | output | 1 | One-cycle strobe: `rx_bit` holds a received write-slot bit |
| rx_bit | output | 1 | Line level sampled in the last write slot |
| reset_seen | output | 1 | One-cycle strobe when a presence pulse completes |

## Verification
Most wrong internal states show at `pull_low` within one slot. A stuck or wrongly sequenced controller state shows up as a presence pulse that is missing, early or the wrong length, or as a read-0 hold that is missing or too long. These are measured in cycles from the line edge that started them. An error in the latched slot direction or bit shows up as a `bit_valid` where none is due, or as a pull in a read-1 slot, within 30 µs of the falling edge. A low-duration counter that fails to clear or saturate shows up as a missing or false presence pulse after the next long low.

// File: rtl/sw_phy_pkg.sv
package sw_phy_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SLOT_ACT,
        ST_SLOT_END,
        ST_LONG_LOW,
        ST_RST_LOW,
        ST_PRES_WAIT,
        ST_PRES_DRIVE
    } phy_state_e;

endpackage

// File: rtl/sw_line_sync.sv
module sw_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_s,
    output logic fall_pulse
);
    logic [STAGES-1:0] chain;
    logic              line_prev;

    // The chain resets to the idle-high level so that leaving reset gives no false edge.
    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b1;
                    else        chain[0] <= line_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b1;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_prev <= 1'b1;
        else        line_prev <= chain[STAGES-1];
    end

    assign line_s     = chain[STAGES-1];
    assign fall_pulse = line_prev & ~chain[STAGES-1];
endmodule

// File: rtl/sw_low_meter.sv
module sw_low_meter #(
    parameter int TMO_CYC = 480,
    parameter int RST_CYC = 1920
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_s,
    output logic long_low,
    output logic rst_low
);
    localparam int CW = $clog2(RST_CYC + 1);
    localparam logic [CW-1:0] TMO_V = CW'(TMO_CYC);
    localparam logic [CW-1:0] RST_V = CW'(RST_CYC);

    logic [CW-1:0] low_cnt;

    // Counts the cycles of the current low period and stops at reset length.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (line_s) begin
            low_cnt <= '0;
        end else if (low_cnt != RST_V) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    assign long_low = (low_cnt >= TMO_V);
    assign rst_low  = (low_cnt == RST_V);
endmodule

// File: rtl/sw_slot_fsm.sv
module sw_slot_fsm
    import sw_phy_pkg::*;
#(
    parameter int SAMP_CYC = 120,
    parameter int HOLD_CYC = 120,
    parameter int PW_CYC   = 120,
    parameter int PL_CYC   = 480
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_s,
    input  logic       fall,
    input  logic       long_low,
    input  logic       rst_low,
    input  logic       mode_read,
    input  logic       tx_bit,
    output logic       pull_low,
    output logic       bit_valid,
    output logic       rx_bit,
    output logic       reset_seen,
    output phy_state_e state_o,
    output logic       rd_lat_o,
    output logic       tx_lat_o
);
    localparam int M1   = (SAMP_CYC > HOLD_CYC) ? SAMP_CYC : HOLD_CYC;
    localparam int M2   = (PW_CYC > PL_CYC) ? PW_CYC : PL_CYC;
    localparam int TMAX = (M1 > M2) ? M1 : M2;
    localparam int TW   = $clog2(TMAX + 1);
    localparam logic [TW-1:0] SAMP_LAST = TW'(SAMP_CYC - 1);
    localparam logic [TW-1:0] HOLD_LAST = TW'(HOLD_CYC - 1);
    localparam logic [TW-1:0] PW_LAST   = TW'(PW_CYC - 1);
    localparam logic [TW-1:0] PL_LAST   = TW'(PL_CYC - 1);

    phy_state_e    state, nxt;
    logic [TW-1:0] tcnt, tcnt_n;
    logic          rd_lat, tx_lat, rd_n, tx_n;

    // Next-state logic.
    always_comb begin
        nxt  = state;
        rd_n = rd_lat;
        tx_n = tx_lat;
        unique case (state)
            ST_IDLE: begin
                if (fall) begin
                    nxt  = ST_SLOT_ACT;
                    rd_n = mode_read;
                    tx_n = tx_bit;
                end
            end
            ST_SLOT_ACT: begin
                if (rd_lat ? (tcnt == HOLD_LAST) : (tcnt == SAMP_LAST))
                    nxt = ST_SLOT_END;
            end
            ST_SLOT_END: begin
                if (rst_low)       nxt = ST_RST_LOW;
                else if (long_low) nxt = ST_LONG_LOW;
                else if (line_s)   nxt = ST_IDLE;
            end
            ST_LONG_LOW: begin
                if (rst_low)       nxt = ST_RST_LOW;
                else if (line_s)   nxt = ST_IDLE;
            end
            ST_RST_LOW: begin
                if (line_s)        nxt = ST_PRES_WAIT;
            end
            ST_PRES_WAIT: begin
                if (tcnt == PW_LAST) nxt = ST_PRES_DRIVE;
            end
            ST_PRES_DRIVE: begin
                if (tcnt == PL_LAST) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
        tcnt_n = (nxt != state) ? '0 : tcnt + 1'b1;
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            tcnt   <= '0;
            rd_lat <= 1'b0;
            tx_lat <= 1'b1;
        end else begin
            state  <= nxt;
            tcnt   <= tcnt_n;
            rd_lat <= rd_n;
            tx_lat <= tx_n;
        end
    end

    // Registered outputs: the pull follows the state being entered, and the strobes mark the exits.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pull_low   <= 1'b0;
            bit_valid  <= 1'b0;
            rx_bit     <= 1'b0;
            reset_seen <= 1'b0;
        end else begin
            pull_low   <= (nxt == ST_PRES_DRIVE) ||
                          ((nxt == ST_SLOT_ACT) && rd_n && !tx_n);
            bit_valid  <= (state == ST_SLOT_ACT) && !rd_lat && (tcnt == SAMP_LAST);
            reset_seen <= (state == ST_PRES_DRIVE) && (tcnt == PL_LAST);
            if ((state == ST_SLOT_ACT) && !rd_lat && (tcnt == SAMP_LAST))
                rx_bit <= line_s;
        end
    end

    assign state_o  = state;
    assign rd_lat_o = rd_lat;
    assign tx_lat_o = tx_lat;
endmodule

// File: rtl/sw_slave_phy.sv
module sw_slave_phy
    import sw_phy_pkg::*;
#(
    parameter int CYC_PER_US   = 4,
    parameter int RST_US       = 480,
    parameter int PRES_WAIT_US = 30,
    parameter int PRES_LEN_US  = 120,
    parameter int SAMPLE_US    = 30,
    parameter int HOLD_US      = 30,
    parameter int SLOT_TMO_US  = 120,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    input  logic mode_read,
    input  logic tx_bit,
    output logic pull_low,
    output logic bit_valid,
    output logic rx_bit,
    output logic reset_seen
);
    localparam int RST_CYC  = RST_US * CYC_PER_US;
    localparam int TMO_CYC  = SLOT_TMO_US * CYC_PER_US;
    localparam int PW_CYC   = PRES_WAIT_US * CYC_PER_US;
    localparam int PL_CYC   = PRES_LEN_US * CYC_PER_US;
    localparam int SAMP_CYC = SAMPLE_US * CYC_PER_US;
    localparam int HOLD_CYC = HOLD_US * CYC_PER_US;

    logic       line_s, fall, long_low, rst_low;
    phy_state_e fsm_state;
    logic       fsm_rd, fsm_tx;

    sw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .line_in(line_in),
        .line_s(line_s), .fall_pulse(fall)
    );

    sw_low_meter #(.TMO_CYC(TMO_CYC), .RST_CYC(RST_CYC)) u_meter (
        .clk(clk), .rst_n(rst_n), .line_s(line_s),
        .long_low(long_low), .rst_low(rst_low)
    );

    sw_slot_fsm #(
        .SAMP_CYC(SAMP_CYC), .HOLD_CYC(HOLD_CYC),
        .PW_CYC(PW_CYC), .PL_CYC(PL_CYC)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .line_s(line_s), .fall(fall),
        .long_low(long_low), .rst_low(rst_low),
        .mode_read(mode_read), .tx_bit(tx_bit),
        .pull_low(pull_low), .bit_valid(bit_valid), .rx_bit(rx_bit),
        .reset_seen(reset_seen),
        .state_o(fsm_state), .rd_lat_o(fsm_rd), .tx_lat_o(fsm_tx)
    );
endmodule

// File: rtl/sw_slave_phy_chk.sv
module sw_slave_phy_chk
    import sw_phy_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       pull_low,
    input logic       bit_valid,
    input logic       reset_seen,
    input phy_state_e state,
    input logic       rd_lat,
    input logic       tx_lat
);
    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_quiet_R1: assert (!pull_low && !bit_valid && !reset_seen);
        end
    end

    assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |=> !bit_valid);

    assert_strobe_after_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> (state == ST_SLOT_END || state == ST_RST_LOW || state == ST_LONG_LOW));

    assert_read_one_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLOT_ACT && rd_lat && tx_lat) |-> !pull_low);

    assert_presence_driven_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PRES_DRIVE) |-> pull_low);

    assert_seen_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reset_seen |=> !reset_seen);

    assert_seen_after_presence_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reset_seen |-> $past(pull_low));

    assert_wait_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PRES_WAIT) |-> (!pull_low && !bit_valid));
endmodule

bind sw_slave_phy sw_slave_phy_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pull_low(pull_low), .bit_valid(bit_valid),
    .reset_seen(reset_seen), .state(fsm_state), .rd_lat(fsm_rd), .tx_lat(fsm_tx)
);

// File: tb/tb_sw_slave_phy.sv
`timescale 1ns/1ps
module tb_sw_slave_phy;
    localparam int US = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_low = 1'b0;
    logic mode_read = 1'b0;
    logic tx_bit = 1'b1;
    logic line_in, pull_low, bit_valid, rx_bit, reset_seen;
    int   n_chk = 0;
    int   n_fail = 0;

    always #2.5 clk = ~clk;
    assign line_in = ~(m_low | pull_low);

    sw_slave_phy #(.CYC_PER_US(US)) dut (
        .clk(clk), .rst_n(rst_n), .line_in(line_in),
        .mode_read(mode_read), .tx_bit(tx_bit),
        .pull_low(pull_low), .bit_valid(bit_valid),
        .rx_bit(rx_bit), .reset_seen(reset_seen)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle_us(input int n);
        repeat (n * US) @(negedge clk);
    endtask

    // Write slot: master holds low for hold_us, then the strobe is checked.
    task automatic write_slot(input int hold_us, input bit exp_bit, input string req,
                              input bit flip_mode);
        int first = -1;
        int cnt = 0;
        int val = -1;
        int pulls = 0;
        mode_read = 1'b0;
        tx_bit = 1'b1;
        @(negedge clk);
        m_low = 1'b1;
        for (int i = 1; i <= 90 * US; i++) begin
            @(negedge clk);
            if (i == hold_us * US) m_low = 1'b0;
            if (flip_mode && i == 4) begin
                mode_read = 1'b1;
                tx_bit = 1'b0;
            end
            if (pull_low) pulls++;
            if (bit_valid) begin
                cnt++;
                if (first < 0) begin
                    first = i;
                    val = int'(rx_bit);
                end
            end
        end
        m_low = 1'b0;
        chk(cnt == 1, {req, " strobe count"}, cnt, 1);
        chk(first >= 30 * US - 2 && first <= 30 * US + 6, {req, " strobe time"}, first, 30 * US + 3);
        chk(val == int'(exp_bit), {req, " rx_bit"}, val, int'(exp_bit));
        if (flip_mode) chk(pulls == 0, "R10 no pull after late mode change", pulls, 0);
        mode_read = 1'b0;
        tx_bit = 1'b1;
        idle_us(10);
    endtask

    task automatic read_slot(input bit b);
        int dur = 0;
        int at15 = 0;
        int at40 = 0;
        int bv = 0;
        mode_read = 1'b1;
        tx_bit = b;
        @(negedge clk);
        m_low = 1'b1;
        for (int i = 1; i <= 70 * US; i++) begin
            @(negedge clk);
            if (i == 2 * US) m_low = 1'b0;
            if (i == 4) tx_bit = ~b;
            if (pull_low) dur++;
            if (bit_valid) bv++;
            if (i == 15 * US) at15 = int'(pull_low);
            if (i == 40 * US) at40 = int'(pull_low);
        end
        if (!b) begin
            chk(at15 == 1, "R3 pull held at 15us", at15, 1);
            chk(at40 == 0, "R3 pull released at 40us", at40, 0);
            chk(dur >= 30 * US - 3 && dur <= 30 * US + 3, "R3 hold length", dur, 30 * US);
            chk(bv == 0, "R3 no strobe in read slot", bv, 0);
        end else begin
            chk(dur == 0, "R4 no pull for read one", dur, 0);
        end
        mode_read = 1'b0;
        tx_bit = 1'b1;
        idle_us(10);
    endtask

    // Reset low of low_us; optional short master glitch inside the presence wait.
    task automatic reset_seq(input int low_us, input bit glitch, input string req);
        int rise = -1;
        int dur = 0;
        int rs = 0;
        int bv = 0;
        int rs_at = -1;
        int drop = -1;
        @(negedge clk);
        m_low = 1'b1;
        idle_us(low_us);
        m_low = 1'b0;
        for (int i = 1; i <= 250 * US; i++) begin
            @(negedge clk);
            if (glitch && i == 10 * US) m_low = 1'b1;
            if (glitch && i == 13 * US) m_low = 1'b0;
            if (pull_low) begin
                dur++;
                if (rise < 0) rise = i;
                drop = i;
            end
            if (bit_valid) bv++;
            if (reset_seen) begin
                rs++;
                rs_at = i;
            end
        end
        chk(rise >= 30 * US - 2 && rise <= 30 * US + 6, {req, " presence start"}, rise, 30 * US + 3);
        chk(dur >= 120 * US - 2 && dur <= 120 * US + 2, {req, " presence length"}, dur, 120 * US);
        chk(rs == 1, "R6 reset_seen count", rs, 1);
        chk(rs_at == drop + 1, "R6 reset_seen after presence", rs_at, drop + 1);
        chk(bv == 0, {req, " no strobe after reset"}, bv, 0);
        idle_us(10);
    endtask

    task automatic long_low_seq();
        int pulls = 0;
        int rs = 0;
        @(negedge clk);
        m_low = 1'b1;
        idle_us(200);
        m_low = 1'b0;
        for (int i = 1; i <= 250 * US; i++) begin
            @(negedge clk);
            if (pull_low) pulls++;
            if (reset_seen) rs++;
        end
        chk(pulls == 0, "R9 no presence after mid-length low", pulls, 0);
        chk(rs == 0, "R9 no reset_seen after mid-length low", rs, 0);
        write_slot(5, 1'b1, "R9 slot after mid-length low", 1'b0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        repeat (5) @(negedge clk);
        chk(!pull_low && !bit_valid && !reset_seen, "R1 outputs in reset",
            int'({pull_low, bit_valid, reset_seen}), 0);
        rst_n = 1'b1;
        idle_us(5);
        chk(!pull_low && !bit_valid && !reset_seen, "R1 outputs after reset",
            int'({pull_low, bit_valid, reset_seen}), 0);
        reset_seq(500, 1'b0, "R5");
        write_slot(5, 1'b1, "R2 write one", 1'b0);
        write_slot(60, 1'b0, "R2 write zero", 1'b0);
        read_slot(1'b0);
        read_slot(1'b1);
        write_slot(5, 1'b1, "R10 latched write", 1'b1);
        reset_seq(500, 1'b1, "R7");
        mode_read = 1'b0;
        reset_seq(600, 1'b0, "R8");
        long_low_seq();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule